// File: doc/BRIEF.md
# Dual-Edge Serial-In Parallel-Out Shift Register

This block is a serial-in, parallel-out shift register that advances once on every transition of its clock, rising and falling alike. A serial bit enters at the low end and every stored bit moves one place toward the high end on each enabled edge. All stages are visible in parallel. An active-high enable gates the shifting. An active-high clear acts asynchronously and wins over everything else.

No flip-flop that triggers on both edges is used. Each stage keeps two ordinary register banks, one clocked on the rising edge and one on the falling edge. The visible word is the XOR of the two banks. On its own edge, a bank stores the wanted new word XOR the other bank's contents, so the XOR then equals the wanted word. Several fixed-width stages are chained inside the top: the most significant bit of one stage feeds the serial input of the next, and all stages share clock, enable and clear.

Top module: `dual_edge_sipo`

## Requirements
- R1: While `clr_i` is high, every bit of `q_o` is 0 at once (within the same time step, without waiting for a clock edge), whatever the clock, `en_i` and `sin_i` do.
- R2: With `en_i` high and `clr_i` low, a rising clock edge performs exactly one shift.
- R3: With `en_i` high and `clr_i` low, a falling clock edge performs exactly one shift.
- R4: A shift sets `q_o[0]` to `sin_i` and sets `q_o[n]` to the old `q_o[n-1]` for every n above 0, so a single 1 shifted in and followed by 0s sits at bit k-1 after k shifts.
- R5: With `en_i` low, clock edges of either polarity leave `q_o` unchanged, whatever `sin_i` is.
- R6: After `clr_i` is released, the first enabled clock edge of either polarity performs the first shift, with no extra latency.
- R7: The `STAGES` stages of `STAGE_W` bits are cascaded. Bit `STAGE_W-1` of a stage feeds bit 0 of the next stage, so the whole `q_o` behaves as one shift register of `STAGES*STAGE_W` bits. With the defaults, bit 8 is bit 0 of the second stage.
- R8: The values of `sin_i` and `en_i` used by an edge are the ones present just before that edge. A change shortly after the edge does not alter the result of that edge.
- R9: With the defaults (`STAGE_W` = 8, `STAGES` = 2), `q_o` is 16 bits wide and index 15 is the most significant output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Shift clock; both edges are active |
| clr_i | input | 1 | Asynchronous clear, active high, highest priority |
| en_i | input | 1 | Shift enable, active high |
| sin_i | input | 1 | Serial data entering bit 0 |
| q_o | output | STAGES*STAGE_W | Parallel outputs of all stages, bit 0 newest |

## Verification
Each shift updates only one bank, so a wrong value in either bank corrupts the XOR at once. The fault shows in `q_o` in the same half period as the edge that wrote it, and it moves up one position on every later edge until it leaves the top bit. A fault in only one bank's enable or capture appears on edges of a single polarity, so the checks are labelled by edge polarity. Faults in the cascade first show at bit `STAGE_W`, exactly `STAGE_W+1` edges after a marker bit enters.

// File: rtl/dsr_pkg.sv
package dsr_pkg;

    // Which clock transition a register bank responds to.
    typedef enum logic {
        EDGE_RISE = 1'b0,
        EDGE_FALL = 1'b1
    } edge_pol_e;

endpackage

// File: rtl/dsr_shift_next.sv
// Computes the word that one shift step produces from the current state.
module dsr_shift_next #(
    parameter int W = 8
) (
    input  logic [W-1:0] state_i,
    input  logic         sin_i,
    output logic [W-1:0] next_o
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        if (i == 0) begin : g_low
            assign next_o[i] = sin_i;
        end else begin : g_up
            assign next_o[i] = state_i[i-1];
        end
    end

endmodule

// File: rtl/dsr_edge_bank.sv
// One single-edge register bank. On its edge it stores target XOR peer so
// that the XOR of both banks afterwards equals the target word.
module dsr_edge_bank #(
    parameter int                W   = 8,
    parameter dsr_pkg::edge_pol_e POL = dsr_pkg::EDGE_RISE
) (
    input  logic         clk_i,
    input  logic         clr_i,
    input  logic         en_i,
    input  logic [W-1:0] target_i,
    input  logic [W-1:0] peer_i,
    output logic [W-1:0] bank_o
);

    typedef struct packed {
        logic [W-1:0] bank;
    } bank_st_t;

    bank_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (en_i) begin
            st_d.bank = target_i ^ peer_i;
        end
    end

    if (POL == dsr_pkg::EDGE_RISE) begin : g_rise
        always_ff @(posedge clk_i or posedge clr_i) begin
            if (clr_i) begin
                st_q <= '0;
            end else begin
                st_q <= st_d;
            end
        end
    end else begin : g_fall
        always_ff @(negedge clk_i or posedge clr_i) begin
            if (clr_i) begin
                st_q <= '0;
            end else begin
                st_q <= st_d;
            end
        end
    end

    assign bank_o = st_q.bank;

endmodule

// File: rtl/dsr_stage.sv
// One cascadable stage built from a rising bank and a falling bank.
module dsr_stage #(
    parameter int W = 8
) (
    input  logic         clk_i,
    input  logic         clr_i,
    input  logic         en_i,
    input  logic         sin_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] rise_bank;
    logic [W-1:0] fall_bank;
    logic [W-1:0] vis;
    logic [W-1:0] tgt;

    assign vis = rise_bank ^ fall_bank;
    assign q_o = vis;

    dsr_shift_next #(.W(W)) u_next (
        .state_i (vis),
        .sin_i   (sin_i),
        .next_o  (tgt)
    );

    dsr_edge_bank #(.W(W), .POL(dsr_pkg::EDGE_RISE)) u_rise (
        .clk_i    (clk_i),
        .clr_i    (clr_i),
        .en_i     (en_i),
        .target_i (tgt),
        .peer_i   (fall_bank),
        .bank_o   (rise_bank)
    );

    dsr_edge_bank #(.W(W), .POL(dsr_pkg::EDGE_FALL)) u_fall (
        .clk_i    (clk_i),
        .clr_i    (clr_i),
        .en_i     (en_i),
        .target_i (tgt),
        .peer_i   (rise_bank),
        .bank_o   (fall_bank)
    );

    // Snapshots of the ports taken at each edge, used only by the checks below.
    typedef struct packed {
        logic [W-1:0] q;
        logic         en;
        logic         sin;
        logic         valid;
    } snap_t;

    snap_t rsnap_d, rsnap_q, fsnap_d, fsnap_q;

    always_comb begin
        rsnap_d       = rsnap_q;
        rsnap_d.q     = q_o;
        rsnap_d.en    = en_i;
        rsnap_d.sin   = sin_i;
        rsnap_d.valid = 1'b1;
        fsnap_d       = rsnap_d;
    end

    always_ff @(posedge clk_i or posedge clr_i) begin
        if (clr_i) begin
            rsnap_q <= '0;
        end else begin
            rsnap_q <= rsnap_d;
        end
    end

    always_ff @(negedge clk_i or posedge clr_i) begin
        if (clr_i) begin
            fsnap_q <= '0;
        end else begin
            fsnap_q <= fsnap_d;
        end
    end

    // R2, R4: a rising edge with enable shifted exactly once.
    a_r2_rise_shift: assert property (@(negedge clk_i) disable iff (clr_i)
        (rsnap_q.valid && rsnap_q.en) |-> (q_o == {rsnap_q.q[W-2:0], rsnap_q.sin}));

    // R3, R4: a falling edge with enable shifted exactly once.
    a_r3_fall_shift: assert property (@(posedge clk_i) disable iff (clr_i)
        (fsnap_q.valid && fsnap_q.en) |-> (q_o == {fsnap_q.q[W-2:0], fsnap_q.sin}));

    // R5: a rising edge without enable changed nothing.
    a_r5_rise_hold: assert property (@(negedge clk_i) disable iff (clr_i)
        (rsnap_q.valid && !rsnap_q.en) |-> (q_o == rsnap_q.q));

    // R5: a falling edge without enable changed nothing.
    a_r5_fall_hold: assert property (@(posedge clk_i) disable iff (clr_i)
        (fsnap_q.valid && !fsnap_q.en) |-> (q_o == fsnap_q.q));

endmodule

// File: rtl/dual_edge_sipo.sv
// Chain of dual-edge stages sharing clock, enable and clear.
module dual_edge_sipo #(
    parameter int STAGE_W = 8,
    parameter int STAGES  = 2
) (
    input  logic                       clk_i,
    input  logic                       clr_i,
    input  logic                       en_i,
    input  logic                       sin_i,
    output logic [STAGES*STAGE_W-1:0]  q_o
);

    localparam int TOTAL_W = STAGES * STAGE_W;

    logic [STAGES:0] link;

    assign link[0] = sin_i;

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        logic [STAGE_W-1:0] sq;

        dsr_stage #(.W(STAGE_W)) u_stage (
            .clk_i (clk_i),
            .clr_i (clr_i),
            .en_i  (en_i),
            .sin_i (link[s]),
            .q_o   (sq)
        );

        assign link[s+1] = sq[STAGE_W-1];
        assign q_o[s*STAGE_W +: STAGE_W] = sq;
    end

    // R1: clear held across a rising edge keeps every output low.
    a_r1_clear_rise: assert property (@(posedge clk_i)
        clr_i |-> (q_o == {TOTAL_W{1'b0}}));

    // R1: clear held across a falling edge keeps every output low.
    a_r1_clear_fall: assert property (@(negedge clk_i)
        clr_i |-> (q_o == {TOTAL_W{1'b0}}));

endmodule

// File: tb/test_dual_edge_sipo.sv
`timescale 1ns/1ps
module test_dual_edge_sipo;

    localparam int SW = 8;
    localparam int NS = 2;
    localparam int N  = SW * NS;

    logic         clk = 1'b0;
    logic         clr = 1'b0;
    logic         en_r = 1'b0;
    logic         sin_r = 1'b0;
    logic [N-1:0] q;
    logic [N-1:0] exp_q = '0;
    int           n_vec = 0;
    int           n_bad = 0;
    logic [15:0]  lfsr = 16'hACE1;

    always #2 clk = ~clk;

    dual_edge_sipo #(.STAGE_W(SW), .STAGES(NS)) i_dual_edge_sipo (
        .clk_i (clk),
        .clr_i (clr),
        .en_i  (en_r),
        .sin_i (sin_r),
        .q_o   (q)
    );

    // Reference: one shift per clock transition, cleared by clr.
    always @(clk or posedge clr) begin
        if (clr) begin
            exp_q <= '0;
        end else if (en_r) begin
            exp_q <= {exp_q[N-2:0], sin_r};
        end
    end

    task automatic check(input string tag, input logic [N-1:0] want);
        n_vec++;
        if (q !== want) begin
            n_bad++;
            $display("FAIL %s: q=%h expected %h", tag, q, want);
        end
    endtask

    // Drive inputs now (1 ns after an edge), wait for the next edge, check 1 ns later.
    task automatic step(input logic en, input logic sin);
        en_r  = en;
        sin_r = sin;
        @(clk);
        #1;
        check(clk ? "R2 rising" : "R3 falling", exp_q);
    endtask

    task automatic t_clear_override;
        #0.5 clr = 1'b1;
        #0.2 check("R1 clear at start", '0);
        @(clk);
        #1;
        for (int i = 0; i < 4; i++) begin
            en_r  = 1'b1;
            sin_r = 1'b1;
            @(clk);
            #1;
            check("R1 clear overrides edges", '0);
        end
    endtask

    task automatic t_first_shift_and_walk;
        clr = 1'b1;
        #0.5 clr = 1'b0;
        en_r  = 1'b1;
        sin_r = 1'b1;
        @(clk);
        #1;
        check("R6 first edge after release", 16'h0001);
        for (int k = 2; k <= N + 1; k++) begin
            en_r  = 1'b1;
            sin_r = 1'b0;
            @(clk);
            #1;
            if (k == SW + 1) begin
                check("R7 marker crosses into stage 1", 16'h0100);
            end else if (k == N) begin
                check("R9 marker at bit 15", 16'h8000);
            end else if (k == N + 1) begin
                check("R4 marker leaves the top", 16'h0000);
            end else begin
                check("R4 marker position", 16'h0001 << (k - 1));
            end
        end
    endtask

    task automatic t_hold;
        logic [N-1:0] saved;
        step(1'b1, 1'b1);
        step(1'b1, 1'b0);
        step(1'b1, 1'b1);
        step(1'b1, 1'b1);
        saved = q;
        for (int i = 0; i < 6; i++) begin
            en_r  = 1'b0;
            sin_r = i[0];
            @(clk);
            #1;
            check(clk ? "R5 hold rising" : "R5 hold falling", saved);
        end
    endtask

    task automatic t_random;
        for (int i = 0; i < 120; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[3] | lfsr[7], lfsr[0]);
        end
    endtask

    task automatic t_late_change;
        en_r  = 1'b1;
        sin_r = 1'b1;
        @(clk);
        #0.3 sin_r = 1'b0;
        #0.7 check("R8 late serial change", exp_q);
        if (q[0] !== 1'b1) begin
            n_bad++;
            $display("FAIL R8: q[0]=%b expected 1", q[0]);
        end
        n_vec++;
        en_r  = 1'b1;
        sin_r = 1'b1;
        @(clk);
        #0.3 en_r = 1'b0;
        #0.7 check("R8 late enable drop", exp_q);
        step(1'b0, 1'b1);
    endtask

    task automatic t_mid_clear;
        step(1'b1, 1'b1);
        step(1'b1, 1'b1);
        #0.3 clr = 1'b1;
        #0.2 check("R1 clear mid half period", '0);
        en_r  = 1'b1;
        sin_r = 1'b1;
        @(clk);
        #0.5 clr = 1'b0;
        #0.5 check("R1 edge during clear ignored", '0);
        step(1'b1, 1'b1);
        if (q !== 16'h0001) begin
            n_bad++;
            $display("FAIL R6: q=%h expected 0001", q);
        end
        n_vec++;
        step(1'b1, 1'b0);
    endtask

    initial begin
        n_vec++;
        if ($bits(q) != 16) begin
            n_bad++;
            $display("FAIL R9: width=%0d expected 16", $bits(q));
        end
        t_clear_override();
        t_first_shift_and_walk();
        t_hold();
        t_random();
        t_late_change();
        t_mid_clear();
        t_random();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 4);
        n_bad++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule